// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator

This block gathers up to sixteen interrupt sources into a single level-type request line for a host processor. Every source feeds a two-flop synchronizer. When the source is enabled, the synchronized level is captured into a sticky pending bit. The request line stays high for as long as any pending bit is also unmasked.

The host reaches the block through a plain synchronous register port. Each register is 16 bits wide, and consecutive registers are 4 bytes apart. Every state change is made with a write of ones to a bit vector: one register unmasks, another masks, a third enables capture, and a write to the pending register acknowledges. The host therefore never needs a read-modify-write, and two handlers can touch different sources without a lock. A pending source with a lower number is serviced first, so the bit order of the pending register is fixed.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset every source is masked and no source is enabled. Every pending bit is clear, `irq_o` is low, and reads of the pending, unmask, mask and enable addresses all return 0.
- R2: `bus_addr` is a byte address. The word index is `bus_addr[7:2]`, and bits 1:0 are ignored. The map is: 0x0 pending/acknowledge, 0x4 unmask (write-one-to-unmask), 0x8 mask (write-one-to-mask), 0xC enable (write-one-to-enable). Data uses bits 15:0. A read of any other word index returns 0.
- R3: A write to the mask address masks every source whose data bit is 1. Data bits that are 0 leave the mask state of that source unchanged.
- R4: A write to the unmask address unmasks every source whose data bit is 1. Data bits that are 0 leave the mask state of that source unchanged.
- R5: A write to the pending address clears each pending bit whose data bit is 1. Data bits that are 0 have no effect. Without such a write, a pending bit never clears.
- R6: A write to the enable address enables capture for every source whose data bit is 1. A source that is not enabled never sets its pending bit.
- R7: A source that goes high is visible in the pending register after the third rising clock edge. The latency comes from two synchronizer flops followed by the pending register.
- R8: If a source is still active when its pending bit is acknowledged, the bit reads as set again immediately after the acknowledge.
- R9: `irq_o` is high exactly when some source is both pending and unmasked. When every source is masked, `irq_o` is low.
- R10: The bring-up writes are all-ones to mask, then all-ones to enable, then all-ones to pending. After them `irq_o` is low, the enable read is 0xFFFF and the mask read is 0. `irq_o` stays low even if sources then go active.
- R11: Pending bit i belongs to source input `src_i[i]`, with bit 0 being source 0.
- R12: Reads at the unmask address and at the mask address both return the current mask state, where 1 means unmasked. A read at the enable address returns the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Asynchronous interrupt source levels |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational from state |
| irq_o | output | 1 | Level interrupt request to the host |

## Verification
Single-source directed patterns establish three things. The first is the bit ordering. The second is the three-edge capture latency, with the pending read sampled before and after the third edge. The third is the difference between an acknowledge while the source is still active and one after it has dropped. Writes of zero data to the mask and pending registers separate write-one semantics from plain overwrite. A second reset with a single enabled source separates enable gating from unconditional capture. A long random phase mixes source levels with writes to valid, unused and misaligned addresses, and it compares every read and the request line against a bench model built from the requirements.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int N_SRC  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] IDX_PEND   = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] IDX_UNMASK = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] IDX_MASK   = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] IDX_ENABLE = WIDX_W'(3);

  logic [N_SRC-1:0] sync1_q, sync2_q;
  logic [N_SRC-1:0] pend_q, mask_q, en_q;
  logic [WIDX_W-1:0] widx;
  logic wr_pend, wr_unmask, wr_mask, wr_en;
  logic unused_lsb;

  assign widx       = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];

  assign wr_pend   = bus_we && (widx == IDX_PEND);
  assign wr_unmask = bus_we && (widx == IDX_UNMASK);
  assign wr_mask   = bus_we && (widx == IDX_MASK);
  assign wr_en     = bus_we && (widx == IDX_ENABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= src_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_mask)
        mask_q <= mask_q | bus_wdata;
      else if (wr_unmask)
        mask_q <= mask_q & ~bus_wdata;
      if (wr_en)
        en_q <= en_q | bus_wdata;
      pend_q <= (pend_q & ~(wr_pend ? bus_wdata : '0)) | (sync2_q & en_q);
    end
  end

  always_comb begin
    case (widx)
      IDX_PEND:   bus_rdata = pend_q;
      IDX_UNMASK: bus_rdata = ~mask_q;
      IDX_MASK:   bus_rdata = ~mask_q;
      IDX_ENABLE: bus_rdata = en_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o = |(pend_q & ~mask_q);

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask_q & $past(bus_wdata)) == '0)); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_q & $past(bus_wdata) & ~$past(sync2_q & en_q)) == '0)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pend |=> ((~pend_q & $past(pend_q)) == '0)); // R5

  AST_ONLY_ENABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0)); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o); // R9

endmodule

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cascade_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // requirement model: 1 in m_mask means masked
  logic [15:0] m_s1, m_s2, m_pend, m_mask, m_en;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_mask <= '1; m_en <= '0;
    end else begin
      m_s1 <= src_i;
      m_s2 <= m_s1;
      if (bus_we && bus_addr[7:2] == 6'd2) m_mask <= m_mask | bus_wdata;
      if (bus_we && bus_addr[7:2] == 6'd1) m_mask <= m_mask & ~bus_wdata;
      if (bus_we && bus_addr[7:2] == 6'd3) m_en <= m_en | bus_wdata;
      m_pend <= (m_pend & ~((bus_we && bus_addr[7:2] == 6'd0) ? bus_wdata : 16'h0)) | (m_s2 & m_en);
    end
  end

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    case (a[7:2])
      6'd0: return m_pend;
      6'd1, 6'd2: return ~m_mask;
      6'd3: return m_en;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_i = '0; bus_we = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #(100000 * 8);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ACE5));
    do_reset();
    // R1 reset state
    rd("R1 pend", 8'h00, 16'h0000);
    rd("R1 unmask", 8'h04, 16'h0000);
    rd("R1 mask", 8'h08, 16'h0000);
    rd("R1 enable", 8'h0C, 16'h0000);
    chk("R1 irq", {15'h0, irq_o}, 16'h0);

    // R10 bring-up
    wr(8'h08, 16'hFFFF);
    wr(8'h0C, 16'hFFFF);
    wr(8'h00, 16'hFFFF);
    rd("R10 enable", 8'h0C, 16'hFFFF);
    rd("R10 mask", 8'h08, 16'h0000);
    chk("R10 irq", {15'h0, irq_o}, 16'h0);

    // R7 / R11 latency and bit order
    src_i = 16'h0001;
    idle(2);
    rd("R7 before third edge", 8'h00, 16'h0000);
    idle(1);
    rd("R11 source0 bit0", 8'h00, 16'h0001);
    chk("R9 masked irq", {15'h0, irq_o}, 16'h0);

    // R4 unmask, R12 readback
    wr(8'h04, 16'h0001);
    #1 chk("R9 irq unmasked", {15'h0, irq_o}, 16'h1);
    rd("R12 unmask read", 8'h04, 16'h0001);
    rd("R12 mask read", 8'h08, 16'h0001);
    // R2 decode
    rd("R2 low bits ignored", 8'h05, 16'h0001);
    rd("R2 unused word", 8'h10, 16'h0000);

    // R8 ack while active, R5 zero write
    wr(8'h00, 16'h0001);
    rd("R8 still active", 8'h00, 16'h0001);
    src_i = 16'h0000;
    idle(3);
    wr(8'h00, 16'h0000);
    rd("R5 zero write keeps", 8'h00, 16'h0001);
    wr(8'h00, 16'h0001);
    rd("R5 ack clears", 8'h00, 16'h0000);
    #1 chk("R9 irq after ack", {15'h0, irq_o}, 16'h0);

    // R3 masking
    src_i = 16'h0001;
    idle(3);
    #1 chk("R9 irq pending", {15'h0, irq_o}, 16'h1);
    wr(8'h08, 16'h0000);
    #1 chk("R3 zero mask write", {15'h0, irq_o}, 16'h1);
    wr(8'h08, 16'h0001);
    #1 chk("R3 masked", {15'h0, irq_o}, 16'h0);

    // R10 sources active after bring-up stay masked
    src_i = 16'hFFFF;
    idle(4);
    #1 chk("R10 active but masked", {15'h0, irq_o}, 16'h0);

    // R6 enable gating
    do_reset();
    wr(8'h0C, 16'h0008);
    wr(8'h04, 16'hFFFF);
    src_i = 16'hFFFF;
    idle(4);
    rd("R6 only enabled", 8'h00, 16'h0008);

    // random phase against model
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) src_i = 16'($urandom);
      bus_we = (($urandom % 3) == 0);
      bus_addr = 8'($urandom % 21);
      bus_wdata = ($urandom % 2) ? 16'($urandom) : (16'h1 << ($urandom % 16));
      #1;
      chk("R9 random irq", {15'h0, irq_o}, {15'h0, |(m_pend & ~m_mask)});
      chk("R2 random read", bus_rdata, exp_read(bus_addr));
    end
    bus_we = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule